// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word between two buses, called A and B, in either direction. The word is never inverted. Each direction has its own four controls: a latch enable, a storage clock, an active-low clock enable and an active-low output enable. With the latch enable high, the destination follows the source. With it low, the destination shows a stored word. That word is reloaded only when the storage clock falls while the clock enable is low.

The design is fully synchronous to one free-running system clock. Every control pin passes through a two-flop synchroniser. The storage clock is an ordinary signal whose falling edge is detected in the system clock domain. Each bus appears as a separate input word, output word and drive-enable pin. Each source bus bit also has a valid qualifier. A bit whose qualifier is low is treated as floating, and it reads as the last level seen while it was driven.

Each source bit and each control takes 3 system clocks from its pin to the destination output: a two-stage synchroniser, then one storage register. The drive-enable output has the same latency as the data.

Top module: `xcvr_dual18`

## Requirements
- R1: While reset is high, and after it until an output enable is sampled low, both drive enables are 0. Reset clears both stored words, so both outputs read 0.
- R2: With a direction's latch enable held high, its destination output equals the source word applied 3 clock cycles earlier, bit for bit with no inversion.
- R3: When the latch enable goes low, the destination keeps the last word that was passing through it.
- R4: With latch enable low and clock enable low, a 1-to-0 change of the storage clock stores the source word that was applied in the same cycle as the clock change. The stored word appears 3 clocks after that change.
- R5: With the clock enable high, falling storage-clock edges do not change the stored word.
- R6: With latch enable low and the storage clock held steady, the stored word does not change.
- R7: The drive-enable output is 1 exactly 3 clocks after the output-enable pin is sampled 0, and 0 when it was sampled 1.
- R8: Storage keeps capturing while the drive enable is 0. The captured word is shown once the drive enable returns to 1.
- R9: The B-to-A direction uses only its own four controls and behaves like A-to-B. Traffic in one direction never changes the other direction's output.
- R10: A source bit whose valid qualifier is 0 takes the level it last had while its qualifier was 1, or 0 if it has not been driven since reset.
- R11: The contention output is 1 exactly when both drive enables are 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 18 | A bus sampled value |
| a_vld_i | input | 18 | Per-bit driven qualifier for A bus |
| a_o | output | 18 | Value for A bus driver (B-to-A path) |
| a_oe_o | output | 1 | A bus driver enable |
| b_i | input | 18 | B bus sampled value |
| b_vld_i | input | 18 | Per-bit driven qualifier for B bus |
| b_o | output | 18 | Value for B bus driver (A-to-B path) |
| b_oe_o | output | 1 | B bus driver enable |
| ab_le_i | input | 1 | A-to-B latch enable, active high |
| ab_cp_i | input | 1 | A-to-B storage clock, falling edge active |
| ab_ce_n_i | input | 1 | A-to-B clock enable, active low |
| ab_oe_n_i | input | 1 | A-to-B output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable, active high |
| ba_cp_i | input | 1 | B-to-A storage clock, falling edge active |
| ba_ce_n_i | input | 1 | B-to-A clock enable, active low |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |
| contention_o | output | 1 | Both buses being driven at once |

## Verification
The hardest situation to reach from the ports is a storage-clock fall that must be ignored or honoured depending on the latch and clock enables as they stood two cycles earlier. A rising latch enable, a falling clock and a changing clock enable can meet in the same synchronised cycle. The bench randomises the storage clock, latch enable and clock enable every cycle in dedicated phases. Every cycle it compares both outputs against a behavioural model that delays the pins by the synchroniser depth. It also runs phases with the drive disabled and with random valid qualifiers, so that hidden stored and held state is exposed later through the outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W      = 18;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic le;
    logic cp;
    logic ce_n;
    logic oe_n;
  } dir_ctrl_t;

  localparam int CTRL_W = $bits(dir_ctrl_t);
  // reset image: latch closed, clock low, clock disabled, output disabled
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0011;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] vld_i,
  output logic [W-1:0] kept_o
);
  logic [W-1:0] hold_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           hold_q[i] <= 1'b0;
      else if (vld_i[i]) hold_q[i] <= in_i[i];
    end
    assign kept_o[i] = vld_i[i] ? in_i[i] : hold_q[i];
  end

  // R10
  keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i == '0) |=> $stable(hold_q));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] src_vld_i,
  input  dir_ctrl_t    ctl_i,
  output logic [W-1:0] dst_o,
  output logic         dst_oe_o,
  output logic         oe_n_sync_o
);
  logic [CTRL_W-1:0] ctl_raw;
  dir_ctrl_t         ctl_s;
  logic [W-1:0]      kept;
  logic [W-1:0]      d_s;
  logic [W-1:0]      store_q;
  logic              cp_prev;
  logic              drv_q;
  logic              fall;

  xcvr_sync #(.W(CTRL_W), .STAGES(STAGES), .RST_VAL(CTRL_RST)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_i), .q(ctl_raw)
  );
  assign ctl_s = dir_ctrl_t'(ctl_raw);

  xcvr_keeper #(.W(W)) u_keep (
    .clk(clk), .rst(rst), .in_i(src_i), .vld_i(src_vld_i), .kept_o(kept)
  );

  xcvr_sync #(.W(W), .STAGES(STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d(kept), .q(d_s)
  );

  assign fall = cp_prev & ~ctl_s.cp;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      cp_prev <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      cp_prev <= ctl_s.cp;
      drv_q   <= ~ctl_s.oe_n;
      if (ctl_s.le)                store_q <= d_s;
      else if (fall && !ctl_s.ce_n) store_q <= d_s;
    end
  end

  assign dst_o       = store_q;
  assign dst_oe_o    = drv_q;
  assign oe_n_sync_o = ctl_s.oe_n;

  // R2
  transparent_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_s.le |=> store_q == $past(d_s));
  // R4
  fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.le && fall && !ctl_s.ce_n) |=> store_q == $past(d_s));
  // R5
  ce_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.le && ctl_s.ce_n) |=> $stable(store_q));
  // R6
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.le && !fall) |=> $stable(store_q));
  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_s.oe_n |=> !dst_oe_o);
endmodule

// File: rtl/xcvr_dual18.sv
module xcvr_dual18
  import xcvr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_vld_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_vld_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_le_i,
  input  logic         ab_cp_i,
  input  logic         ab_ce_n_i,
  input  logic         ab_oe_n_i,
  input  logic         ba_le_i,
  input  logic         ba_cp_i,
  input  logic         ba_ce_n_i,
  input  logic         ba_oe_n_i,
  output logic         contention_o
);
  dir_ctrl_t ab_ctl, ba_ctl;
  logic      ab_oe_n_s, ba_oe_n_s;
  logic      cont_q;

  assign ab_ctl = '{le: ab_le_i, cp: ab_cp_i, ce_n: ab_ce_n_i, oe_n: ab_oe_n_i};
  assign ba_ctl = '{le: ba_le_i, cp: ba_cp_i, ce_n: ba_ce_n_i, oe_n: ba_oe_n_i};

  xcvr_lane #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .src_i(a_i), .src_vld_i(a_vld_i), .ctl_i(ab_ctl),
    .dst_o(b_o), .dst_oe_o(b_oe_o), .oe_n_sync_o(ab_oe_n_s)
  );

  xcvr_lane #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .src_i(b_i), .src_vld_i(b_vld_i), .ctl_i(ba_ctl),
    .dst_o(a_o), .dst_oe_o(a_oe_o), .oe_n_sync_o(ba_oe_n_s)
  );

  always_ff @(posedge clk) begin
    if (rst) cont_q <= 1'b0;
    else     cont_q <= ~ab_oe_n_s & ~ba_oe_n_s;
  end
  assign contention_o = cont_q;

  // R11
  contention_match_chk: assert property (@(posedge clk) disable iff (rst)
    contention_o |-> (a_oe_o && b_oe_o));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));
endmodule

// File: tb/xcvr_dual18_tb.sv
module xcvr_dual18_tb;
  localparam int W = 18;
  localparam int WATCHDOG = 50000;

  typedef struct {
    int le;
    int cp;
    int ce;
    int oe;
  } cfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0] src [2];
  logic [W-1:0] vld [2];
  logic le [2], cp [2], cen [2], oen [2];

  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o, contention_o;

  xcvr_dual18 u_dut (
    .clk(clk), .rst(rst),
    .a_i(src[0]), .a_vld_i(vld[0]), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(src[1]), .b_vld_i(vld[1]), .b_o(b_o), .b_oe_o(b_oe_o),
    .ab_le_i(le[0]), .ab_cp_i(cp[0]), .ab_ce_n_i(cen[0]), .ab_oe_n_i(oen[0]),
    .ba_le_i(le[1]), .ba_cp_i(cp[1]), .ba_ce_n_i(cen[1]), .ba_oe_n_i(oen[1]),
    .contention_o(contention_o)
  );

  // behavioural model: index 0 = A-to-B, index 1 = B-to-A
  logic [W-1:0] m_hold [2], m_d1 [2], m_d2 [2], m_store [2];
  logic m_le1 [2], m_le2 [2], m_cp1 [2], m_cp2 [2], m_cpp [2];
  logic m_ce1 [2], m_ce2 [2], m_oe1 [2], m_oe2 [2], m_drv [2];
  logic m_cont;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always @(posedge clk) begin
    logic [W-1:0] kept;
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_hold[d] = '0; m_d1[d] = '0; m_d2[d] = '0; m_store[d] = '0;
        m_le1[d] = 0; m_le2[d] = 0; m_cp1[d] = 0; m_cp2[d] = 0; m_cpp[d] = 0;
        m_ce1[d] = 1; m_ce2[d] = 1; m_oe1[d] = 1; m_oe2[d] = 1; m_drv[d] = 0;
      end
      m_cont = 0;
    end else begin
      m_cont = !m_oe2[0] && !m_oe2[1];
      for (int d = 0; d < 2; d++) begin
        kept = (src[d] & vld[d]) | (m_hold[d] & ~vld[d]);
        if (m_le2[d]) m_store[d] = m_d2[d];
        else if (m_cpp[d] && !m_cp2[d] && !m_ce2[d]) m_store[d] = m_d2[d];
        m_cpp[d] = m_cp2[d];
        m_drv[d] = !m_oe2[d];
        m_d2[d] = m_d1[d]; m_d1[d] = kept; m_hold[d] = kept;
        m_le2[d] = m_le1[d]; m_le1[d] = le[d];
        m_cp2[d] = m_cp1[d]; m_cp1[d] = cp[d];
        m_ce2[d] = m_ce1[d]; m_ce1[d] = cen[d];
        m_oe2[d] = m_oe1[d]; m_oe1[d] = oen[d];
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(string tag);
    tests++;
    if (b_o !== m_store[0] || a_o !== m_store[1] || b_oe_o !== m_drv[0] ||
        a_oe_o !== m_drv[1] || contention_o !== m_cont) begin
      fails++;
      $display("FAIL %s: actual b=%h a=%h boe=%b aoe=%b cont=%b expected b=%h a=%h boe=%b aoe=%b cont=%b",
               tag, b_o, a_o, b_oe_o, a_oe_o, contention_o,
               m_store[0], m_store[1], m_drv[0], m_drv[1], m_cont);
    end
  endtask

  function automatic logic pick(int m);
    logic [31:0] r;
    if (m == 0) return 1'b0;
    if (m == 1) return 1'b1;
    r = $urandom;
    return r[0];
  endfunction

  task automatic run_phase(string tag, int n, cfg_t c0, cfg_t c1, bit rnd_vld);
    cfg_t c [2];
    logic [31:0] r;
    c[0] = c0; c[1] = c1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tag);
      for (int d = 0; d < 2; d++) begin
        r = $urandom; src[d] = r[W-1:0];
        r = $urandom; vld[d] = rnd_vld ? r[W-1:0] : '1;
        le[d] = pick(c[d].le); cp[d] = pick(c[d].cp);
        cen[d] = pick(c[d].ce); oen[d] = pick(c[d].oe);
      end
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      src[d] = '0; vld[d] = '1; le[d] = 0; cp[d] = 0; cen[d] = 1; oen[d] = 1;
    end
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1");
    end
    rst = 1'b0;
    run_phase("R1", 4, '{0,0,1,1}, '{0,0,1,1}, 0);
    // R2: transparent, B driven
    run_phase("R2", 40, '{1,0,1,0}, '{0,0,1,1}, 0);
    // R3: latch enable toggling, clock steady low
    run_phase("R3", 60, '{2,0,0,0}, '{2,0,0,0}, 0);
    // R4: capture on falls with clock enable low
    run_phase("R4", 80, '{0,2,0,0}, '{0,2,0,0}, 0);
    // R5: clock enable high blocks falls
    run_phase("R5", 60, '{0,2,1,0}, '{0,2,1,0}, 0);
    // R6: hold with steady clock high
    run_phase("R6", 40, '{0,1,0,0}, '{0,1,0,0}, 0);
    // R7: output enable toggling
    run_phase("R7", 60, '{1,0,1,2}, '{1,0,1,2}, 0);
    // R8: capture with drive off, then show it
    run_phase("R8", 50, '{0,2,0,1}, '{0,2,0,1}, 0);
    run_phase("R8", 20, '{0,0,1,0}, '{0,0,1,0}, 0);
    // R9: directions independent, B-to-A busy while A-to-B holds
    run_phase("R9", 60, '{0,0,1,0}, '{2,2,2,0}, 0);
    // R10: floating bits keep last level
    run_phase("R10", 80, '{1,0,1,0}, '{2,2,0,0}, 1);
    // R11: contention
    run_phase("R11", 60, '{2,2,2,2}, '{2,2,2,2}, 0);
    // full random mix
    run_phase("R2", 200, '{2,2,2,2}, '{2,2,2,2}, 1);
    summary();
    $finish;
  end
endmodule